// File: doc/BRIEF.md
# Multichannel Converter Command Receiver

This block is the serial slave front end of a sixteen-channel converter controller. A host sends 24-bit command words over a three-wire link (serial clock, active-low chip select, serial data). Each word carries a 16-bit sample value, a 4-bit channel number and two mode bits. The block samples the link into its own system clock, rebuilds each word and writes the sample into a 16-entry channel store. It also latches the two mode bits and merges them with two external mode pins into the effective update mode and sequencer clock-source selection.

Several words may follow one another inside a single chip-select frame. Each one goes to its own channel. A frame that ends partway through a word is reported and its partial bits are dropped. A word whose reserved positions are not zero is still stored, but a warning pulse is raised. A one-cycle write strobe carries the channel number of every committed word to downstream logic, for example an immediate-update path. A read port returns the stored value of any channel.

Top module: `dac_cmd_rx`

## Requirements
- R1: Bits are taken MSB first, one per rising serial-clock edge while chip select is low, and the first rising edge after chip select falls supplies word bit 23. Word bits [23:8] are the sample, [7:4] the channel number (0 to 15), [3] a reserved zero, [2] the update-mode bit, [1] the clock-source bit and [0] a fill zero. A completed word writes its sample to that channel, and the value is returned on `rd_data_o` one clock after `rd_addr_i` is presented.
- R2: For each completed word, `wr_stb_o` is high for exactly one clock, and `wr_addr_o` shows the word's channel number in that cycle. `wr_addr_o` holds that value until the next word.
- R3: Several whole words sent inside one chip-select frame are each stored to their own channel and each give one strobe.
- R4: When chip select rises with a partial word (1 to 23 bits) collected, nothing is written, no strobe occurs, and `frame_err_o` pulses for one clock. A frame that holds only whole words raises no error.
- R5: A completed word with bit [3] or bit [0] set is still stored and strobed, and `fmt_warn_o` is high in the same cycle as its strobe.
- R6: `immed_mode_o` is the OR of the last latched update-mode bit (1 = immediate, 0 = burst) and the `ext_immed_i` pin, registered one clock.
- R7: `ext_clk_mode_o` is the OR of the last latched clock-source bit (1 = external, 0 = internal) and the `ext_clksel_i` pin, registered one clock.
- R8: Synchronous reset clears the strobe, channel output, error, warning and both latched mode bits.
- R9: Chip select going high always returns the bit count to zero, so the next frame starts a fresh word at its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_n_i | input | 1 | Active-low chip select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| ext_immed_i | input | 1 | External immediate-update request |
| ext_clksel_i | input | 1 | External clock-source request |
| rd_addr_i | input | 4 | Channel to read |
| rd_data_o | output | 16 | Stored sample of the requested channel |
| wr_stb_o | output | 1 | One-cycle pulse per committed word |
| wr_addr_o | output | 4 | Channel of the last committed word |
| immed_mode_o | output | 1 | Effective immediate-update mode |
| ext_clk_mode_o | output | 1 | Effective external clock-source mode |
| frame_err_o | output | 1 | One-cycle pulse on a truncated word |
| fmt_warn_o | output | 1 | One-cycle pulse on a word with nonzero reserved bits |

## Verification
The functions that can collide are a channel write and a read of the same channel. When the bench sweeps the read address while words land, a read and a write to one channel fall in the same clock, and the returned value must be the old contents. A second collision is a word commit and a change of an external mode pin. The mode output must then reflect the old latched bit in that cycle and the new one a clock later. A behavioural model fed with the same pin samples predicts every output on every clock, so these collisions are judged exactly where they occur.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  // Low four bits of every command word, after sample and channel fields
  typedef struct packed {
    logic rsv;    // must be zero
    logic c_upd;  // 1 = immediate update, 0 = burst
    logic c_clk;  // 1 = external sequencer clock
    logic fill;   // must be zero
  } cmd_tail_t;

  localparam int TAIL_W = $bits(cmd_tail_t);
endpackage

// File: rtl/dac_cmd_sync.sv
module dac_cmd_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dac_cmd_shifter.sv
module dac_cmd_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_err_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic              sclk_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;

  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d      <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      word_o      <= '0;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      sclk_d      <= sclk_s;
      word_vld_o  <= 1'b0;
      frame_err_o <= 1'b0;
      if (cs_n_s) begin
        frame_err_o <= (bit_cnt != '0);
        bit_cnt     <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-3:0], sdi_s};
        if (bit_cnt == LAST) begin
          word_o     <= {shreg, sdi_s};
          word_vld_o <= 1'b1;
          bit_cnt    <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_cmd_regfile.sv
module dac_cmd_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single-clock memory, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic              ext_immed_i,
  input  logic              ext_clksel_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              immed_mode_o,
  output logic              ext_clk_mode_o,
  output logic              frame_err_o,
  output logic              fmt_warn_o
);
  localparam int WORD_W = DATA_W + ADDR_W + TAIL_W;

  logic [2:0]        pins_s;
  logic              word_vld;
  logic              ferr_int;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] w_data;
  logic [ADDR_W-1:0] w_addr;
  cmd_tail_t         w_tail;
  logic              lat_upd;
  logic              lat_clk;

  // bit 2: sclk, bit 1: cs_n (idles high), bit 0: sdi
  dac_cmd_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sclk_i, cs_n_i, sdi_i}),
    .q_o (pins_s)
  );

  dac_cmd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (pins_s[2]),
    .cs_n_s      (pins_s[1]),
    .sdi_s       (pins_s[0]),
    .word_vld_o  (word_vld),
    .word_o      (word),
    .frame_err_o (ferr_int)
  );

  assign w_data = word[WORD_W-1 -: DATA_W];
  assign w_addr = word[TAIL_W +: ADDR_W];
  assign w_tail = cmd_tail_t'(word[TAIL_W-1:0]);

  dac_cmd_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (word_vld),
    .waddr_i (w_addr),
    .wdata_i (w_data),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o       <= 1'b0;
      wr_addr_o      <= '0;
      fmt_warn_o     <= 1'b0;
      frame_err_o    <= 1'b0;
      lat_upd        <= 1'b0;
      lat_clk        <= 1'b0;
      immed_mode_o   <= 1'b0;
      ext_clk_mode_o <= 1'b0;
    end else begin
      wr_stb_o       <= word_vld;
      fmt_warn_o     <= word_vld & (w_tail.rsv | w_tail.fill);
      frame_err_o    <= ferr_int;
      immed_mode_o   <= lat_upd | ext_immed_i;
      ext_clk_mode_o <= lat_clk | ext_clksel_i;
      if (word_vld) begin
        wr_addr_o <= w_addr;
        lat_upd   <= w_tail.c_upd;
        lat_clk   <= w_tail.c_clk;
      end
    end
  end
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk (
  input logic clk,
  input logic rst,
  input logic ext_immed_i,
  input logic ext_clksel_i,
  input logic wr_stb_o,
  input logic immed_mode_o,
  input logic ext_clk_mode_o,
  input logic frame_err_o,
  input logic fmt_warn_o
);
  a_r2_stb_single: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |=> !frame_err_o);

  a_r4_err_no_stb: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> !wr_stb_o);

  a_r5_warn_on_stb: assert property (@(posedge clk) disable iff (rst)
    fmt_warn_o |-> wr_stb_o);

  a_r6_pin_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ext_immed_i)) |-> immed_mode_o);

  a_r7_pin_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ext_clksel_i)) |-> ext_clk_mode_o);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!wr_stb_o && !frame_err_o && !fmt_warn_o));
endmodule

bind dac_cmd_rx dac_cmd_rx_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .ext_immed_i    (ext_immed_i),
  .ext_clksel_i   (ext_clksel_i),
  .wr_stb_o       (wr_stb_o),
  .immed_mode_o   (immed_mode_o),
  .ext_clk_mode_o (ext_clk_mode_o),
  .frame_err_o    (frame_err_o),
  .fmt_warn_o     (fmt_warn_o)
);

// File: tb/dac_cmd_rx_test.sv
`timescale 1ns/1ps
module dac_cmd_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic ext_imm = 1'b0, ext_cks = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        stb, ferr, warn, imm, cks;
  logic [3:0]  waddr;

  int checks = 0, errors = 0, stb_count = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_cmd_rx uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .ext_immed_i(ext_imm), .ext_clksel_i(ext_cks), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_stb_o(stb), .wr_addr_o(waddr),
    .immed_mode_o(imm), .ext_clk_mode_o(cks), .frame_err_o(ferr),
    .fmt_warn_o(warn)
  );

  // ---------------- behavioural reference model ----------------
  logic hsc[4], hcs[4], hsd[4];           // pin history, [0] newest
  int   nbits;
  logic [23:0] acc;
  logic a_v, a_f, a_w, a_c1, a_c0;
  logic [15:0] a_d;
  logic [3:0]  a_a;
  logic [15:0] mem [16];
  logic [15:0] known;
  logic m_c1, m_c0;
  logic e_stb, e_ferr, e_warn, e_imm, e_cks, e_rd_ok;
  logic [3:0]  e_addr;
  logic [15:0] e_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin hsc[i] = 0; hcs[i] = 1; hsd[i] = 0; end
      nbits = 0; acc = '0; a_v = 0; a_f = 0; a_w = 0; a_c1 = 0; a_c0 = 0;
      a_d = '0; a_a = '0; known = '0; m_c1 = 0; m_c0 = 0;
      e_stb = 0; e_ferr = 0; e_warn = 0; e_imm = 0; e_cks = 0; e_addr = '0;
      e_rd_ok = 0; e_rd = '0;
    end else begin
      e_stb   = a_v;
      e_ferr  = a_f;
      e_warn  = a_v & a_w;
      if (a_v) e_addr = a_a;
      e_rd_ok = known[rd_addr];
      e_rd    = mem[rd_addr];
      e_imm   = m_c1 | ext_imm;
      e_cks   = m_c0 | ext_cks;
      if (a_v) begin mem[a_a] = a_d; known[a_a] = 1; m_c1 = a_c1; m_c0 = a_c0; end
      for (int i = 3; i > 0; i--) begin hsc[i] = hsc[i-1]; hcs[i] = hcs[i-1]; hsd[i] = hsd[i-1]; end
      hsc[0] = sclk; hcs[0] = cs_n; hsd[0] = sdi;
      a_v = 0; a_f = 0;
      if (hcs[2]) begin
        if (nbits != 0) a_f = 1;
        nbits = 0;
      end else if (hsc[2] && !hsc[3]) begin
        acc = {acc[22:0], hsd[2]};
        nbits++;
        if (nbits == 24) begin
          nbits = 0; a_v = 1;
          a_d = acc[23:8]; a_a = acc[7:4];
          a_w = acc[3] | acc[0]; a_c1 = acc[2]; a_c0 = acc[1];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 wr_stb", stb, e_stb);
      chk("R2 wr_addr", waddr, e_addr);
      chk("R4 frame_err", ferr, e_ferr);
      chk("R5 fmt_warn", warn, e_warn);
      chk("R6 immed_mode", imm, e_imm);
      chk("R7 ext_clk_mode", cks, e_cks);
      if (e_rd_ok) chk("R1 rd_data", rd_data, e_rd);
      if (stb === 1'b1) stb_count++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 23; i > 23 - n; i--) begin
      sdi = w[i]; sclk = 1'b0; wait_clk(3);
      sclk = 1'b1; wait_clk(3);
    end
    sclk = 1'b0; wait_clk(3);
  endtask

  function automatic logic [23:0] mk(input logic [15:0] d, input logic [3:0] a,
                                     input logic c1, input logic c0);
    return {d, a, 1'b0, c1, c0, 1'b0};
  endfunction

  task automatic frame(input logic [23:0] w);
    cs_n = 1'b0; wait_clk(3);
    send_bits(w, 24);
    cs_n = 1'b1; wait_clk(8);
  endtask

  task automatic read_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a; wait_clk(2);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    int base;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    // R8: reset state
    chk("R8 reset stb", stb, 0);
    chk("R8 reset err", ferr, 0);
    chk("R8 reset modes", {imm, cks}, 0);
    chk("R8 reset addr", waddr, 0);

    // R1: single word, immediate mode
    frame(mk(16'hA5C3, 4'd5, 1, 0));
    read_chk(4'd5, 16'hA5C3, "R1 single word ch5");
    chk("R6 latched immediate", imm, 1);

    // R3: three words in one frame
    base = stb_count;
    cs_n = 1'b0; wait_clk(3);
    send_bits(mk(16'h1111, 4'd0, 0, 1), 24);
    send_bits(mk(16'hFFFF, 4'd15, 0, 0), 24);
    send_bits(mk(16'h7E81, 4'd7, 0, 1), 24);
    cs_n = 1'b1; wait_clk(8);
    chk("R3 three strobes", stb_count - base, 3);
    read_chk(4'd0, 16'h1111, "R3 ch0");
    read_chk(4'd15, 16'hFFFF, "R3 ch15");
    read_chk(4'd7, 16'h7E81, "R3 ch7");
    chk("R7 latched ext clock", cks, 1);

    // R4 / R9: truncated word then a fresh word
    base = stb_count;
    cs_n = 1'b0; wait_clk(3);
    send_bits(mk(16'h0BAD, 4'd5, 1, 1), 10);
    cs_n = 1'b1; wait_clk(8);
    chk("R4 no store on partial", stb_count - base, 0);
    read_chk(4'd5, 16'hA5C3, "R4 ch5 unchanged");
    frame(mk(16'h3C3C, 4'd5, 0, 0));
    read_chk(4'd5, 16'h3C3C, "R9 fresh word after partial");

    // R4: whole word plus five extra bits
    base = stb_count;
    cs_n = 1'b0; wait_clk(3);
    send_bits(mk(16'h2468, 4'd9, 0, 0), 24);
    send_bits(24'hFFFFFF, 5);
    cs_n = 1'b1; wait_clk(8);
    chk("R4 whole word kept", stb_count - base, 1);
    read_chk(4'd9, 16'h2468, "R4 ch9");

    // R5: reserved and fill bits set
    frame({16'h5555, 4'd3, 4'b1001});
    read_chk(4'd3, 16'h5555, "R5 stored despite warning");

    // R6/R7: external pins with latched bits zero
    ext_imm = 1'b1; wait_clk(3);
    chk("R6 pin alone", imm, 1);
    ext_imm = 1'b0; ext_cks = 1'b1; wait_clk(3);
    chk("R6 pin released", imm, 0);
    chk("R7 pin alone", cks, 1);
    ext_cks = 1'b0;

    // all channels, read address sweeping during writes
    fork
      begin
        cs_n = 1'b0; wait_clk(3);
        for (int c = 0; c < 16; c++) send_bits(mk(16'h1000 + 16'(c * 257), 4'(c), 4'(c) == 4'd6, c[0]), 24);
        cs_n = 1'b1; wait_clk(8);
      end
      begin
        for (int k = 0; k < 2400; k++) begin
          @(negedge clk); rd_addr = rd_addr + 4'd1;
          if (k % 97 == 0) ext_imm = ~ext_imm;
        end
      end
    join
    ext_imm = 1'b0;
    for (int c = 0; c < 16; c++) read_chk(4'(c), 16'h1000 + 16'(c * 257), "R1 sweep");

    wait_clk(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule